// File: doc/BRIEF.md
# Parallel Divisible-by-Three Detector

This block is a purely combinational test that tells whether an unsigned word of `WIDTH` bits is an exact multiple of three. It reads the word as a string of base-4 digits, starting from the least significant end. It adds those digits modulo three in a balanced tree of small adders. Each partial residue travels on two wires. The pair codes `00` and `11` both stand for residue zero, `01` stands for one and `10` stands for two.

It is meant to sit inside wider datapaths as a cheap flag, for example for radix checks or mod-3 steering. There is no clock, no register and no state. The flag follows the input after the delay of roughly log2(`WIDTH`) adder stages plus one final equality gate. Because the block has no state machine, its only "state" is the settled value of the tree. The flag has two outcomes, divisible (1) and not divisible (0), and it moves between them only when `data_in` changes.

Top module: `div3_detect`

## Requirements
- R1: `div_by3` is 1 exactly when the unsigned value of `data_in` modulo 3 equals 0, for every value and every `WIDTH` of 1 or more.
- R2: Digits are taken two bits at a time from bit 0 upward (digit j = bits 2j+1..2j, read as 2·hi + lo). When `WIDTH` is odd, the top digit holds the last input bit as `lo` with `hi` forced to 0. This is exercised at widths 5, 7 and 31.
- R3: A digit or partial sum with both wires high (code `11`, value three) counts as residue 0. Inputs made only of `11` digits (3, 15, 255) give `div_by3` = 1.
- R4: With `WIDTH` = 1, `div_by3` equals the inverse of `data_in[0]`.
- R5: With `WIDTH` = 2, `div_by3` equals the XNOR of `data_in[1]` and `data_in[0]` (values 0 and 3 give 1; values 1 and 2 give 0).
- R6: An all-zero input gives `div_by3` = 1 at every width.
- R7: An all-ones input gives `div_by3` = 1 when `WIDTH` is even and 0 when `WIDTH` is odd.
- R8: The block holds no state. `div_by3` reflects the present `data_in` with no clock edge in between, and a later input change alters it without any edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Unsigned word under test |
| div_by3 | output | 1 | 1 when `data_in` is a multiple of three |

## Verification
Every result is due zero cycles after its stimulus. The output is a settled combinational function of the input, so the bench applies a new word just after a rising clock edge and reads the flag at the following falling edge, half a period later. One directed check changes the input between edges and reads the flag one time unit later, with no edge between the change and the read, to show that no register sits in the path. The bound checker compares the root residue pair and the flag with an arithmetic remainder of the same input whenever the input settles.

// File: rtl/div3_pkg.sv
package div3_pkg;

    // Two-wire residue: value is (2*hi + lo) mod 3, so 00 and 11 both mean zero.
    typedef struct packed {
        logic hi;
        logic lo;
    } res_pair_t;

    // Number of base-4 digits for a word of the given width.
    function automatic int digit_count(input int width);
        return (width + 1) / 2;
    endfunction

    // Nodes alive at a given tree level: ceil(pairs / 2**lvl).
    function automatic int nodes_at_level(input int lvl, input int pairs);
        return (pairs + (1 << lvl) - 1) >> lvl;
    endfunction

endpackage

// File: rtl/div3_digit_split.sv
module div3_digit_split
    import div3_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int NDIGIT = digit_count(WIDTH)
) (
    input  logic [WIDTH-1:0] bits_in,
    output res_pair_t        digits [NDIGIT]
);

    for (genvar j = 0; j < NDIGIT; j++) begin : g_digit
        if (2 * j + 1 < WIDTH) begin : g_full
            assign digits[j] = '{hi: bits_in[2*j+1], lo: bits_in[2*j]};
        end else begin : g_pad
            // odd width: top digit gets a constant-zero high wire
            assign digits[j] = '{hi: 1'b0, lo: bits_in[2*j]};
        end
    end

endmodule

// File: rtl/div3_pair_add.sv
module div3_pair_add
    import div3_pkg::*;
(
    input  res_pair_t a,
    input  res_pair_t b,
    output res_pair_t sum
);

    logic a_one, a_two, b_one, b_two;

    // Normalise to one-hot flags; code 11 becomes neither (residue 0).
    always_comb begin
        a_one = a.lo & ~a.hi;
        a_two = a.hi & ~a.lo;
        b_one = b.lo & ~b.hi;
        b_two = b.hi & ~b.lo;
    end

    always_comb begin
        sum.lo = (a_two & b_two) | (a_one ^ b_one);
        sum.hi = (a_one & b_one) | (a_two ^ b_two);
    end

endmodule

// File: rtl/div3_reduce_tree.sv
module div3_reduce_tree
    import div3_pkg::*;
#(
    parameter int NDIGIT = 16
) (
    input  res_pair_t leaves [NDIGIT],
    output res_pair_t root
);

    localparam int DEPTH = $clog2(NDIGIT);

    for (genvar k = 0; k <= DEPTH; k++) begin : g_lvl
        localparam int CNT = nodes_at_level(k, NDIGIT);
        res_pair_t nodes [CNT];

        if (k == 0) begin : g_leaf
            for (genvar j = 0; j < CNT; j++) begin : g_copy
                assign nodes[j] = leaves[j];
            end
        end else begin : g_merge
            localparam int PREV = nodes_at_level(k - 1, NDIGIT);
            for (genvar j = 0; j < CNT; j++) begin : g_node
                if (2 * j + 1 < PREV) begin : g_add
                    div3_pair_add u_add (
                        .a   (g_lvl[k-1].nodes[2*j]),
                        .b   (g_lvl[k-1].nodes[2*j+1]),
                        .sum (nodes[j])
                    );
                end else begin : g_pass
                    // leftover node rides up one level untouched
                    assign nodes[j] = g_lvl[k-1].nodes[2*j];
                end
            end
        end
    end

    assign root = g_lvl[DEPTH].nodes[0];

endmodule

// File: rtl/div3_detect.sv
module div3_detect
    import div3_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] data_in,
    output logic             div_by3
);

    localparam int NDIGIT = digit_count(WIDTH);

    res_pair_t digits [NDIGIT];
    res_pair_t root_pair;

    div3_digit_split #(
        .WIDTH  (WIDTH),
        .NDIGIT (NDIGIT)
    ) u_split (
        .bits_in (data_in),
        .digits  (digits)
    );

    div3_reduce_tree #(
        .NDIGIT (NDIGIT)
    ) u_tree (
        .leaves (digits),
        .root   (root_pair)
    );

    // residue zero when both wires agree (00 or 11)
    assign div_by3 = ~(root_pair.hi ^ root_pair.lo);

endmodule

// File: rtl/div3_detect_chk.sv
module div3_detect_chk
    import div3_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] data_in,
    input res_pair_t        root_pair,
    input logic             div_by3
);

    logic [WIDTH+1:0] wide_val;
    logic [1:0]       want_res;
    logic [1:0]       root_res;

    always_comb begin
        wide_val = {2'b00, data_in};
        want_res = 2'(wide_val % (WIDTH+2)'(3));
        root_res = 2'(({1'b0, root_pair.hi, 1'b0} + {2'b00, root_pair.lo}) % 3'd3);

        a_r1_flag_matches_mod : assert (div_by3 == (want_res == 2'd0))
            else $error("R1 flag mismatch");
        a_r2_root_residue : assert (root_res == want_res)
            else $error("R2 root residue mismatch");
        if (data_in == '0) begin
            a_r6_zero_divisible : assert (div_by3)
                else $error("R6 zero not flagged");
        end
        if (data_in == '1) begin
            a_r7_all_ones : assert (div_by3 == (WIDTH % 2 == 0))
                else $error("R7 all-ones parity rule");
        end
        if (WIDTH == 1) begin
            a_r4_single_bit : assert (div_by3 == ~data_in[0])
                else $error("R4 single bit");
        end
    end

endmodule

bind div3_detect div3_detect_chk #(.WIDTH(WIDTH)) u_chk (
    .data_in   (data_in),
    .root_pair (root_pair),
    .div_by3   (div_by3)
);

// File: tb/div3_detect_test.sv
module div3_detect_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [15:0] v16;
    logic [0:0]  v1;
    logic [1:0]  v2;
    logic [4:0]  v5;
    logic [6:0]  v7;
    logic [30:0] v31;
    logic [31:0] v32;
    logic [63:0] v64;
    logic f16, f1, f2, f5, f7, f31, f32, f64;

    div3_detect #(.WIDTH(16)) uut   (.data_in(v16), .div_by3(f16));
    div3_detect #(.WIDTH(1))  u_w1  (.data_in(v1),  .div_by3(f1));
    div3_detect #(.WIDTH(2))  u_w2  (.data_in(v2),  .div_by3(f2));
    div3_detect #(.WIDTH(5))  u_w5  (.data_in(v5),  .div_by3(f5));
    div3_detect #(.WIDTH(7))  u_w7  (.data_in(v7),  .div_by3(f7));
    div3_detect #(.WIDTH(31)) u_w31 (.data_in(v31), .div_by3(f31));
    div3_detect #(.WIDTH(32)) u_w32 (.data_in(v32), .div_by3(f32));
    div3_detect #(.WIDTH(64)) u_w64 (.data_in(v64), .div_by3(f64));

    function automatic logic ref_div3(input logic [63:0] v);
        return (v % 64'd3) == 64'd0;
    endfunction

    task automatic check(input string req, input logic act, input logic exp,
                         input logic [63:0] val);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s value=%0d actual=%b expected=%b", req, val, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic apply_wide(input logic [63:0] w);
        @(posedge clk);
        v31 = w[30:0];
        v32 = w[31:0];
        v64 = w;
        @(negedge clk);
        check("R2 odd width 31", f31, ref_div3({33'd0, v31}), {33'd0, v31});
        check("R1 width 32", f32, ref_div3({32'd0, v32}), {32'd0, v32});
        check("R1 width 64", f64, ref_div3(v64), v64);
    endtask

    initial begin
        v16 = '0; v1 = '0; v2 = '0; v5 = '0; v7 = '0;
        v31 = '0; v32 = '0; v64 = '0;
        @(negedge clk);
        // R6: zero at every width
        check("R6 zero w16", f16, 1'b1, 0);
        check("R6 zero w1",  f1,  1'b1, 0);
        check("R6 zero w5",  f5,  1'b1, 0);
        check("R6 zero w31", f31, 1'b1, 0);
        check("R6 zero w64", f64, 1'b1, 0);

        // Exhaustive over 16 bits, slices feed the narrow widths
        for (int i = 0; i < 65536; i++) begin
            @(posedge clk);
            v16 = 16'(i);
            v1  = 1'(i);
            v2  = 2'(i);
            v5  = 5'(i);
            v7  = 7'(i);
            @(negedge clk);
            check("R1 w16", f16, ref_div3(64'(i)), 64'(i));
            check("R4 w1 not bit", f1, ~v1[0], {63'd0, v1});
            check("R5 w2 xnor", f2, ~(v2[1] ^ v2[0]), {62'd0, v2});
            check("R2 odd width 5", f5, ref_div3({59'd0, v5}), {59'd0, v5});
            check("R2 odd width 7", f7, ref_div3({57'd0, v7}), {57'd0, v7});
        end

        // R3: values made only of 11 digits
        @(posedge clk);
        v16 = 16'd3; v64 = 64'd15; v32 = 32'd255;
        @(negedge clk);
        check("R3 code11 val3",   f16, 1'b1, 3);
        check("R3 code11 val15",  f64, 1'b1, 15);
        check("R3 code11 val255", f32, 1'b1, 255);

        // R7: all ones
        @(posedge clk);
        v16 = '1; v5 = '1; v7 = '1; v31 = '1; v32 = '1; v64 = '1; v1 = '1;
        @(negedge clk);
        check("R7 ones w16", f16, 1'b1, {48'd0, v16});
        check("R7 ones w32", f32, 1'b1, {32'd0, v32});
        check("R7 ones w64", f64, 1'b1, v64);
        check("R7 ones w5",  f5,  1'b0, {59'd0, v5});
        check("R7 ones w7",  f7,  1'b0, {57'd0, v7});
        check("R7 ones w31", f31, 1'b0, {33'd0, v31});
        check("R7 ones w1",  f1,  1'b0, 1);

        // R8: change between edges, read without an edge
        @(negedge clk);
        v64 = 64'd7;
        #1;
        check("R8 no edge 7", f64, 1'b0, 7);
        v64 = 64'd9;
        #1;
        check("R8 no edge 9", f64, 1'b1, 9);

        // Random wide words with a fixed seed
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] w;
            w = {$urandom(), $urandom()};
            if (n % 3 == 0) w = w - (w % 64'd3);   // bias toward multiples
            apply_wide(w);
        end
        apply_wide(64'hFFFF_FFFF_FFFF_FFFE);
        apply_wide(64'h8000_0000_0000_0000);
        apply_wide(64'h5555_5555_5555_5555);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule